// File: doc/BRIEF.md
# Dual-Path Peripheral Register Space

A byte-wide register file that holds the control and status registers of a set of peripherals. It has two ways in. The port path carries its own 6-bit register number. It supports whole-byte writes and combinational reads. It also supports three single-bit commands: set, clear and test. The data path reaches the same registers through a 64-byte window in a 16-bit data address space. The window starts 0x20 above the port numbering, so data address 0x20 + n selects register n. Each register slot is one of three kinds, fixed at elaboration: plain read/write, status register, or reserved. In a status register some bits are flags that hardware sets and software clears by writing one.

The single-bit set and clear commands are carried out as a read-modify-write of the whole byte in one cycle. The byte written back is the current byte with one bit changed. As a result, every status flag that reads as set in that byte receives a one and is cleared. Bit commands are accepted only in the lower half of the register space. A bit command above it, or a write that targets a reserved slot, changes nothing and raises a one-cycle error strobe.

Top module: `iosp_regfile`

## Requirements
- R1: With `io_op` = 1 (write), `io_wdata` is stored in plain register `io_addr` at the next rising edge. `io_rdata` always shows the stored byte of `io_addr` combinationally. Op codes: 0 idle, 1 write, 2 set bit, 3 clear bit, 4 test bit; codes 5 to 7 act as idle.
- R2: A data address in 0x20..0x5F raises `dm_hit`, and `dm_rdata` shows register (address − 0x20). A write with `dm_we` stores `dm_wdata` there. Outside that window, `dm_hit` is low, `dm_rdata` is zero and writes change nothing.
- R3: Set bit (2) and clear bit (3) on a register number 0x00..0x1F force bit `io_bit` of that byte to 1 or to 0 at the next edge. The other plain bits keep their values.
- R4: A set, clear or test command on a register number 0x20..0x3F changes no register.
- R5: Test bit (4) on 0x00..0x1F drives `io_cond` with bit `io_bit` of that byte in the same cycle. `io_cond` is 0 for any other command or register number.
- R6: Status registers sit at 0x08, 0x09 and 0x38. Bits [3:0] are flags: a written 1 clears a flag, a written 0 leaves it alone. Bits [5:4] are plain read/write.
- R7: A set or clear command on a status register writes back the byte it read, with one bit changed. Every flag that was set and is written back as 1 is cleared. Clear bit on a set flag therefore keeps that flag and clears all the other set flags.
- R8: `hw_set_en` sets the flag bits `hw_set_bits` & 0x0F of status register `hw_set_addr`. A set and a clear of the same flag in one cycle leave the flag set.
- R9: Slots 0x04..0x07 and 0x3C..0x3F are reserved. They read zero on both paths and ignore every write and bit command.
- R10: Bits [7:6] of a status register read zero whatever is written. Hardware set events outside bits [3:0] have no effect.
- R11: A synchronous reset clears every register and the error strobe.
- R12: If both paths write in the same cycle, the port path wins on the same register. Writes to different registers both take effect.
- R13: `err_pulse` is high for exactly the cycle after a bit command on 0x20..0x3F, or after any write or set/clear command on a reserved slot. Otherwise it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| io_op | input | 3 | Port-path command code |
| io_addr | input | 6 | Port-path register number |
| io_bit | input | 3 | Bit index for set/clear/test |
| io_wdata | input | 8 | Port-path write byte |
| io_rdata | output | 8 | Port-path read byte (combinational) |
| io_cond | output | 1 | Bit-test result |
| dm_addr | input | 16 | Data-path address |
| dm_we | input | 1 | Data-path write enable |
| dm_wdata | input | 8 | Data-path write byte |
| dm_rdata | output | 8 | Data-path read byte (combinational) |
| dm_hit | output | 1 | Data address falls inside the register window |
| hw_set_en | input | 1 | Hardware flag-set event |
| hw_set_addr | input | 6 | Register number for the flag-set event |
| hw_set_bits | input | 8 | Flag bits to set |
| err_pulse | output | 1 | One-cycle error strobe |

## Verification
A hardware flag-set event can land in the same cycle as a software clear of the same status register. The clear can come from a write-one byte write or from the side effect of a set/clear command's read-modify-write. The bench drives `hw_set_en` in the same cycle as a byte write of 0x0F to that register. It then reads the byte back and expects only the freshly set flag to survive, while the flags that were set before are gone. Two writes from the two paths also meet in one cycle, once at the same register and once at different registers. The bench checks that the port byte wins the collision and that both bytes land when the targets differ.

// File: rtl/iosp_pkg.sv
package iosp_pkg;

   typedef enum logic [2:0] {
      IOP_IDLE  = 3'd0,
      IOP_WRITE = 3'd1,
      IOP_SETB  = 3'd2,
      IOP_CLRB  = 3'd3,
      IOP_TESTB = 3'd4
   } iop_e;

   typedef enum logic [1:0] {
      SLOT_PLAIN,
      SLOT_FLAG,
      SLOT_VOID
   } slot_e;

   function automatic slot_e slot_kind(input logic is_void, input logic is_flag);
      if (is_void)      return SLOT_VOID;
      else if (is_flag) return SLOT_FLAG;
      else              return SLOT_PLAIN;
   endfunction

endpackage

// File: rtl/iosp_decode.sv
module iosp_decode
   import iosp_pkg::*;
#(
   parameter int                      ADDR_W   = 6,
   parameter int                      DATA_W   = 8,
   parameter int                      DM_W     = 16,
   parameter int                      DM_BASE  = 32,
   parameter logic [(1<<ADDR_W)-1:0]  VOID_MAP = '0
) (
   input  iop_e                        op,
   input  logic [ADDR_W-1:0]           io_addr,
   input  logic [$clog2(DATA_W)-1:0]   io_bit,
   input  logic [DATA_W-1:0]           io_wdata,
   input  logic [DATA_W-1:0]           io_cur,
   input  logic [DM_W-1:0]             dm_addr,
   input  logic                        dm_we,
   output logic                        a_en,
   output logic [DATA_W-1:0]           a_val,
   output logic                        b_en,
   output logic [ADDR_W-1:0]           dm_idx,
   output logic                        dm_hit,
   output logic                        io_cond,
   output logic                        err_now
);
   localparam int              NREG  = 1 << ADDR_W;
   localparam logic [DM_W-1:0] DM_LO = DM_W'(DM_BASE);
   localparam logic [DM_W-1:0] DM_HI = DM_W'(DM_BASE + NREG);

   logic              is_bitop, bit_ok, io_void, a_wants;
   logic [DATA_W-1:0] bit_sel;

   assign is_bitop = (op == IOP_SETB) || (op == IOP_CLRB) || (op == IOP_TESTB);
   assign bit_ok   = !io_addr[ADDR_W-1];               // lower half only
   assign io_void  = VOID_MAP[io_addr];
   assign bit_sel  = DATA_W'(1) << io_bit;

   assign a_wants = (op == IOP_WRITE) ||
                    (((op == IOP_SETB) || (op == IOP_CLRB)) && bit_ok);
   assign a_en    = a_wants && !io_void;

   always_comb begin
      unique case (op)
         IOP_SETB: a_val = io_cur | bit_sel;
         IOP_CLRB: a_val = io_cur & ~bit_sel;
         default:  a_val = io_wdata;
      endcase
   end

   assign dm_hit  = (dm_addr >= DM_LO) && (dm_addr < DM_HI);
   assign dm_idx  = ADDR_W'(dm_addr - DM_LO);
   assign b_en    = dm_we && dm_hit && !VOID_MAP[dm_idx];

   assign io_cond = (op == IOP_TESTB) && bit_ok && io_cur[io_bit];

   assign err_now = (is_bitop && !bit_ok) ||
                    (a_wants && io_void) ||
                    (dm_we && dm_hit && VOID_MAP[dm_idx]);

endmodule

// File: rtl/iosp_cell.sv
module iosp_cell #(
   parameter int                DATA_W     = 8,
   parameter logic [DATA_W-1:0] RW_MASK    = '1,
   parameter logic [DATA_W-1:0] FLAG_MASK  = '0,
   parameter logic [DATA_W-1:0] RESET_BYTE = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_val,
   input  logic              hw_en,
   input  logic [DATA_W-1:0] hw_bits,
   output logic [DATA_W-1:0] q
);
   localparam logic [DATA_W-1:0] KEEP = RW_MASK | FLAG_MASK;

   logic [DATA_W-1:0] wr_ones, rw_next, flag_next;

   assign wr_ones   = wr_en ? wr_val : '0;
   assign rw_next   = (wr_en ? wr_val : q) & RW_MASK;
   // a hardware set is ORed in after the clear, so it wins a same-cycle collision
   assign flag_next = (q & FLAG_MASK & ~wr_ones) | (hw_en ? (hw_bits & FLAG_MASK) : '0);

   always_ff @(posedge clk) begin
      if (rst) q <= RESET_BYTE & KEEP;
      else     q <= rw_next | flag_next;
   end

endmodule

// File: rtl/iosp_regfile.sv
module iosp_regfile
   import iosp_pkg::*;
#(
   parameter int                      ADDR_W       = 6,
   parameter int                      DATA_W       = 8,
   parameter int                      DM_W         = 16,
   parameter int                      DM_BASE      = 32,
   parameter logic [(1<<ADDR_W)-1:0]  VOID_MAP     = 64'hF000_0000_0000_00F0,
   parameter logic [(1<<ADDR_W)-1:0]  FLAG_MAP     = 64'h0100_0000_0000_0300,
   parameter logic [DATA_W-1:0]       FLAG_BITS    = 8'h0F,
   parameter logic [DATA_W-1:0]       FLAG_RW_BITS = 8'h30,
   parameter logic [DATA_W-1:0]       RESET_BYTE   = 8'h00
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic [2:0]                io_op,
   input  logic [ADDR_W-1:0]         io_addr,
   input  logic [$clog2(DATA_W)-1:0] io_bit,
   input  logic [DATA_W-1:0]         io_wdata,
   output logic [DATA_W-1:0]         io_rdata,
   output logic                      io_cond,
   input  logic [DM_W-1:0]           dm_addr,
   input  logic                      dm_we,
   input  logic [DATA_W-1:0]         dm_wdata,
   output logic [DATA_W-1:0]         dm_rdata,
   output logic                      dm_hit,
   input  logic                      hw_set_en,
   input  logic [ADDR_W-1:0]         hw_set_addr,
   input  logic [DATA_W-1:0]         hw_set_bits,
   output logic                      err_pulse
);
   localparam int NREG = 1 << ADDR_W;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("iosp_regfile: ADDR_W must be at least 2");
   end
   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
      $error("iosp_regfile: DATA_W must be a power of two >= 2");
   end
   if (DM_BASE + NREG > (1 << DM_W)) begin : g_bad_window
      $error("iosp_regfile: data window exceeds data address space");
   end
   if ((FLAG_BITS & FLAG_RW_BITS) != '0) begin : g_bad_masks
      $error("iosp_regfile: flag and read/write masks overlap");
   end

   logic [NREG-1:0][DATA_W-1:0] reg_q;
   iop_e                        op;
   logic                        a_en, b_en, dm_hit_w, err_now, err_q;
   logic [DATA_W-1:0]           a_val;
   logic [ADDR_W-1:0]           dm_idx;

   assign op = iop_e'(io_op);

   iosp_decode #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DM_W(DM_W),
      .DM_BASE(DM_BASE), .VOID_MAP(VOID_MAP)
   ) u_dec (
      .op(op), .io_addr(io_addr), .io_bit(io_bit), .io_wdata(io_wdata),
      .io_cur(reg_q[io_addr]), .dm_addr(dm_addr), .dm_we(dm_we),
      .a_en(a_en), .a_val(a_val), .b_en(b_en), .dm_idx(dm_idx),
      .dm_hit(dm_hit_w), .io_cond(io_cond), .err_now(err_now)
   );

   for (genvar i = 0; i < NREG; i++) begin : g_slot
      localparam logic [ADDR_W-1:0] IDX  = ADDR_W'(i);
      localparam slot_e             KIND = slot_kind(VOID_MAP[i], FLAG_MAP[i]);
      if (KIND == SLOT_VOID) begin : g_void
         assign reg_q[i] = '0;
      end else begin : g_store
         logic sel_a, sel_b, hw_hit;
         assign sel_a  = a_en && (io_addr == IDX);
         assign sel_b  = b_en && (dm_idx == IDX);
         assign hw_hit = hw_set_en && (hw_set_addr == IDX);
         iosp_cell #(
            .DATA_W    (DATA_W),
            .RW_MASK   ((KIND == SLOT_FLAG) ? FLAG_RW_BITS : {DATA_W{1'b1}}),
            .FLAG_MASK ((KIND == SLOT_FLAG) ? FLAG_BITS    : {DATA_W{1'b0}}),
            .RESET_BYTE(RESET_BYTE)
         ) u_cell (
            .clk(clk), .rst(rst),
            .wr_en  (sel_a || sel_b),
            .wr_val (sel_a ? a_val : dm_wdata),   // port path has priority
            .hw_en  (hw_hit),
            .hw_bits(hw_set_bits),
            .q      (reg_q[i])
         );
      end
   end

   always_ff @(posedge clk) begin
      if (rst) err_q <= 1'b0;
      else     err_q <= err_now;
   end

   assign io_rdata  = reg_q[io_addr];
   assign dm_hit    = dm_hit_w;
   assign dm_rdata  = dm_hit_w ? reg_q[dm_idx] : '0;
   assign err_pulse = err_q;

endmodule

// File: rtl/iosp_regfile_chk.sv
module iosp_regfile_chk #(
   parameter int                      ADDR_W    = 6,
   parameter int                      DATA_W    = 8,
   parameter int                      DM_W      = 16,
   parameter int                      DM_BASE   = 32,
   parameter logic [(1<<ADDR_W)-1:0]  VOID_MAP  = '0,
   parameter logic [(1<<ADDR_W)-1:0]  FLAG_MAP  = '0,
   parameter logic [DATA_W-1:0]       FLAG_BITS = '0
) (
   input logic                                clk,
   input logic                                rst,
   input logic [2:0]                          io_op,
   input logic [ADDR_W-1:0]                   io_addr,
   input logic [DATA_W-1:0]                   io_rdata,
   input logic                                io_cond,
   input logic [DM_W-1:0]                     dm_addr,
   input logic                                dm_we,
   input logic [DATA_W-1:0]                   dm_rdata,
   input logic                                dm_hit,
   input logic                                hw_set_en,
   input logic [ADDR_W-1:0]                   hw_set_addr,
   input logic [DATA_W-1:0]                   hw_set_bits,
   input logic                                err_pulse,
   input logic [(1<<ADDR_W)-1:0][DATA_W-1:0]  regs
);
   localparam int NREG = 1 << ADDR_W;

   logic bitop, high, in_win;
   assign bitop  = (io_op == 3'd2) || (io_op == 3'd3) || (io_op == 3'd4);
   assign high   = io_addr[ADDR_W-1];
   assign in_win = (32'(dm_addr) >= DM_BASE) && (32'(dm_addr) < DM_BASE + NREG);

   AST_BITOP_HIGH_ERR: assert property (@(posedge clk) disable iff (rst)
      (bitop && high) |=> err_pulse);                                        // R13

   AST_BITOP_HIGH_NOCHG: assert property (@(posedge clk) disable iff (rst)
      (bitop && high && !dm_we && !hw_set_en) |=> $stable(regs));            // R4

   AST_TEST_HIGH_COND: assert property (@(posedge clk) disable iff (rst)
      (io_op == 3'd4 && high) |-> !io_cond);                                 // R5

   AST_VOID_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
      VOID_MAP[io_addr] |-> (io_rdata == '0));                               // R9

   AST_DM_MISS: assert property (@(posedge clk) disable iff (rst)
      !in_win |-> (!dm_hit && dm_rdata == '0));                              // R2

   AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      (hw_set_en && FLAG_MAP[hw_set_addr]) |=>
      ((regs[$past(hw_set_addr)] & $past(hw_set_bits) & FLAG_BITS) ==
       ($past(hw_set_bits) & FLAG_BITS)));                                   // R8

endmodule

bind iosp_regfile iosp_regfile_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DM_W(DM_W), .DM_BASE(DM_BASE),
   .VOID_MAP(VOID_MAP), .FLAG_MAP(FLAG_MAP), .FLAG_BITS(FLAG_BITS)
) chk_i (
   .clk(clk), .rst(rst), .io_op(io_op), .io_addr(io_addr), .io_rdata(io_rdata),
   .io_cond(io_cond), .dm_addr(dm_addr), .dm_we(dm_we), .dm_rdata(dm_rdata),
   .dm_hit(dm_hit), .hw_set_en(hw_set_en), .hw_set_addr(hw_set_addr),
   .hw_set_bits(hw_set_bits), .err_pulse(err_pulse), .regs(reg_q)
);

// File: tb/iosp_regfile_tb_top.sv
module iosp_regfile_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] OP_IDLE = 3'd0, OP_WR = 3'd1, OP_SET = 3'd2,
                          OP_CLR = 3'd3, OP_TST = 3'd4;

   logic        clk = 1'b0, rst = 1'b1;
   logic [2:0]  io_op = '0;
   logic [5:0]  io_addr = '0;
   logic [2:0]  io_bit = '0;
   logic [7:0]  io_wdata = '0, io_rdata;
   logic        io_cond;
   logic [15:0] dm_addr = '0;
   logic        dm_we = 1'b0;
   logic [7:0]  dm_wdata = '0, dm_rdata;
   logic        dm_hit;
   logic        hw_set_en = 1'b0;
   logic [5:0]  hw_set_addr = '0;
   logic [7:0]  hw_set_bits = '0;
   logic        err_pulse;

   int n_checks = 0, n_fail = 0;
   logic cond_seen, hit_seen, err_seen;

   always #(CLK_PERIOD/2) clk = ~clk;

   iosp_regfile dut_i (
      .clk(clk), .rst(rst), .io_op(io_op), .io_addr(io_addr), .io_bit(io_bit),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .io_cond(io_cond),
      .dm_addr(dm_addr), .dm_we(dm_we), .dm_wdata(dm_wdata), .dm_rdata(dm_rdata),
      .dm_hit(dm_hit), .hw_set_en(hw_set_en), .hw_set_addr(hw_set_addr),
      .hw_set_bits(hw_set_bits), .err_pulse(err_pulse)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic go_idle();
      io_op = OP_IDLE; dm_we = 1'b0; hw_set_en = 1'b0;
   endtask

   // one clock with the given stimulus; captures comb outputs and the error strobe
   task automatic cycle(input logic [2:0] op, input logic [5:0] a, input logic [2:0] b,
                        input logic [7:0] wd, input logic dwe, input logic [15:0] da,
                        input logic [7:0] dwd, input logic hen, input logic [5:0] ha,
                        input logic [7:0] hb);
      @(negedge clk);
      io_op = op; io_addr = a; io_bit = b; io_wdata = wd;
      dm_we = dwe; dm_addr = da; dm_wdata = dwd;
      hw_set_en = hen; hw_set_addr = ha; hw_set_bits = hb;
      #1;
      cond_seen = io_cond; hit_seen = dm_hit;
      @(negedge clk);
      err_seen = err_pulse;
      go_idle();
   endtask

   task automatic io_cmd(input logic [2:0] op, input logic [5:0] a, input logic [2:0] b,
                         input logic [7:0] wd);
      cycle(op, a, b, wd, 1'b0, 16'h0, 8'h0, 1'b0, 6'h0, 8'h0);
   endtask

   task automatic hw_set(input logic [5:0] a, input logic [7:0] bits);
      cycle(OP_IDLE, 6'h0, 3'd0, 8'h0, 1'b0, 16'h0, 8'h0, 1'b1, a, bits);
   endtask

   task automatic peek(input logic [5:0] a, output logic [7:0] d);
      io_op = OP_IDLE; io_addr = a; #1; d = io_rdata;
   endtask

   task automatic expect_reg(input string tag, input logic [5:0] a, input logic [7:0] exp);
      logic [7:0] d;
      peek(a, d);
      check(tag, int'(d), int'(exp));
   endtask

   task automatic t_reset();
      for (int a = 0; a < 64; a++) expect_reg("R11 reset value", 6'(a), 8'h00);
      check("R11 err after reset", int'(err_pulse), 0);
   endtask

   task automatic t_byte_write();
      io_cmd(OP_WR, 6'h3A, 3'd0, 8'hA5); expect_reg("R1 write 0x3A", 6'h3A, 8'hA5);
      check("R13 no err on legal write", int'(err_seen), 0);
      io_cmd(OP_WR, 6'h00, 3'd0, 8'h5A); expect_reg("R1 write 0x00", 6'h00, 8'h5A);
      io_cmd(OP_WR, 6'h0B, 3'd0, 8'hC3); expect_reg("R1 write 0x0B", 6'h0B, 8'hC3);
      dm_addr = 16'h005A; #1;
      check("R2 dm read of 0x3A", int'(dm_rdata), 8'hA5);
      check("R2 dm hit", int'(dm_hit), 1);
   endtask

   task automatic t_dm_path();
      cycle(OP_IDLE, 6'h0, 3'd0, 8'h0, 1'b1, 16'h002A, 8'h77, 1'b0, 6'h0, 8'h0);
      expect_reg("R2 dm write lands at 0x0A", 6'h0A, 8'h77);
      cycle(OP_IDLE, 6'h0, 3'd0, 8'h0, 1'b1, 16'h0060, 8'hEE, 1'b0, 6'h0, 8'h0);
      check("R2 hit low above window", int'(hit_seen), 0);
      expect_reg("R2 write above window ignored", 6'h00, 8'h5A);
      cycle(OP_IDLE, 6'h0, 3'd0, 8'h0, 1'b1, 16'h001A, 8'hEE, 1'b0, 6'h0, 8'h0);
      check("R2 hit low below window", int'(hit_seen), 0);
      expect_reg("R2 write below window ignored", 6'h3A, 8'hA5);
      dm_addr = 16'h0060; #1;
      check("R2 read outside window is zero", int'(dm_rdata), 0);
   endtask

   task automatic t_bit_ops();
      io_cmd(OP_SET, 6'h0A, 3'd3, 8'h00); expect_reg("R3 set bit 3", 6'h0A, 8'h7F);
      io_cmd(OP_CLR, 6'h0A, 3'd0, 8'hFF); expect_reg("R3 clear bit 0", 6'h0A, 8'h7E);
      io_cmd(OP_TST, 6'h0A, 3'd1, 8'h00); check("R5 test set bit", int'(cond_seen), 1);
      io_cmd(OP_TST, 6'h0A, 3'd0, 8'h00); check("R5 test clear bit", int'(cond_seen), 0);
      expect_reg("R5 test leaves byte", 6'h0A, 8'h7E);
   endtask

   task automatic t_bitop_high();
      io_cmd(OP_SET, 6'h3A, 3'd1, 8'h00);
      expect_reg("R4 set above 0x1F ignored", 6'h3A, 8'hA5);
      check("R13 err on high set", int'(err_seen), 1);
      @(negedge clk); check("R13 err lasts one cycle", int'(err_pulse), 0);
      io_cmd(OP_WR, 6'h20, 3'd0, 8'hFF);
      io_cmd(OP_CLR, 6'h20, 3'd4, 8'h00);
      expect_reg("R4 clear above 0x1F ignored", 6'h20, 8'hFF);
      check("R13 err on high clear", int'(err_seen), 1);
      io_cmd(OP_TST, 6'h20, 3'd0, 8'h00);
      check("R5 test above 0x1F gives 0", int'(cond_seen), 0);
      check("R13 err on high test", int'(err_seen), 1);
   endtask

   task automatic t_w1c();
      hw_set(6'h08, 8'h0F); expect_reg("R8 hw sets flags", 6'h08, 8'h0F);
      io_cmd(OP_WR, 6'h08, 3'd0, 8'h35); expect_reg("R6 write-one clears", 6'h08, 8'h3A);
      io_cmd(OP_WR, 6'h08, 3'd0, 8'h00); expect_reg("R6 write-zero keeps", 6'h08, 8'h0A);
   endtask

   task automatic t_priority();
      cycle(OP_WR, 6'h08, 3'd0, 8'h0F, 1'b0, 16'h0, 8'h0, 1'b1, 6'h08, 8'h02);
      expect_reg("R8 set beats clear", 6'h08, 8'h02);
   endtask

   task automatic t_rmw();
      hw_set(6'h09, 8'h05); expect_reg("R8 hw set 0x09", 6'h09, 8'h05);
      io_cmd(OP_SET, 6'h09, 3'd4, 8'h00); expect_reg("R7 set bit clears flags", 6'h09, 8'h10);
      hw_set(6'h09, 8'h06); expect_reg("R8 hw set again", 6'h09, 8'h16);
      io_cmd(OP_CLR, 6'h09, 3'd1, 8'h00); expect_reg("R7 clear bit keeps target flag", 6'h09, 8'h12);
   endtask

   task automatic t_void();
      io_cmd(OP_WR, 6'h05, 3'd0, 8'hFF);
      expect_reg("R9 reserved write ignored", 6'h05, 8'h00);
      check("R13 err on reserved write", int'(err_seen), 1);
      cycle(OP_IDLE, 6'h0, 3'd0, 8'h0, 1'b1, 16'h005D, 8'hFF, 1'b0, 6'h0, 8'h0);
      expect_reg("R9 reserved dm write ignored", 6'h3D, 8'h00);
      check("R13 err on reserved dm write", int'(err_seen), 1);
      io_cmd(OP_SET, 6'h06, 3'd0, 8'h00);
      expect_reg("R9 reserved set ignored", 6'h06, 8'h00);
      check("R13 err on reserved set", int'(err_seen), 1);
   endtask

   task automatic t_void_bits();
      io_cmd(OP_WR, 6'h38, 3'd0, 8'hFF); expect_reg("R10 reserved bits read zero", 6'h38, 8'h30);
      hw_set(6'h38, 8'hF0); expect_reg("R10 hw set outside flags ignored", 6'h38, 8'h30);
   endtask

   task automatic t_dual();
      cycle(OP_WR, 6'h10, 3'd0, 8'h11, 1'b1, 16'h0030, 8'h22, 1'b0, 6'h0, 8'h0);
      expect_reg("R12 port wins same target", 6'h10, 8'h11);
      cycle(OP_WR, 6'h11, 3'd0, 8'h33, 1'b1, 16'h0032, 8'h44, 1'b0, 6'h0, 8'h0);
      expect_reg("R12 port byte lands", 6'h11, 8'h33);
      expect_reg("R12 dm byte lands", 6'h12, 8'h44);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      t_reset();
      t_byte_write();
      t_dm_path();
      t_bit_ops();
      t_bitop_high();
      t_w1c();
      t_priority();
      t_rmw();
      t_void();
      t_void_bits();
      t_dual();
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule